// File: doc/BRIEF.md
# Shared-Multiplier Complex Bin Accumulator

This block keeps running complex sums for a large set of frequency bins while using only one complex multiplier per lane. Every accepted input sample is multiplied, one bin per clock, by a stored complex weight for that bin. Each product is added into the bin's accumulator. The accumulators are held in a dual-ported memory, not in a register bank. A shared sequencer walks the bin addresses and feeds every lane in lockstep, so a design with `LANES` lanes of `BINS_PER_LANE` bins each covers `LANES*BINS_PER_LANE` bins in one sweep of `BINS_PER_LANE` clocks.

The memory path runs as read, multiply, add, write-back. Results still in flight are forwarded to later reads of the same bin, so back-to-back sweeps stay exact. A second read port returns any bin's sum without disturbing the sweep. A clear request zeroes every accumulator in one sweep. Weights are loaded through a simple write port addressed by global bin number. The global bin number is `lane*BINS_PER_LANE + local`, where `local` counts from 0.

Top module: `binmac_bank`

## Requirements
- R1: After reset, `busy` and `overflow` are 0 and `rd_re`/`rd_im` read 0 until a bin is read.
- R2: A clear request accepted while idle writes zero into every bin within one sweep, and `busy` is 1 from the cycle after acceptance.
- R3: A sample presented while a sweep is running, and not on its final bin step, is ignored: it changes no sum and `overflow` is 1 for exactly the following cycle.
- R4: For each bin g with weight (br, bi), a sample (ar, ai) adds ar*br − ai*bi to the real sum and ar*bi + ai*br to the imaginary sum.
- R5: Sums accumulate over successive samples.
- R6: After a sample or clear is accepted from idle, `busy` stays 1 for exactly `BINS_PER_LANE`+2 cycles.
- R7: A new sample accepted on the final step of the previous sweep starts a sweep at once, and every bin still receives both contributions exactly.
- R8: `rd_re`/`rd_im` show the sum of bin `rd_bin` one cycle after `rd_bin` is applied, and reads made during a sweep do not change the sweep length.
- R9: Global bin g maps to lane g / `BINS_PER_LANE` and local slot g mod `BINS_PER_LANE`; writing a weight affects only that bin.
- R10: If a clear and a sample arrive together while idle, the clear wins and the sample is dropped without `overflow`; a clear arriving mid-sweep (not on the final step) is ignored.
- R11: Products are sign-extended into the `ACC_W`-bit sums, so full-scale negative inputs give correct signed results; sums wrap modulo 2^`ACC_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_re | input | DATA_W | Sample real part, signed |
| smp_im | input | DATA_W | Sample imaginary part, signed |
| clr_req | input | 1 | Request to zero all sums |
| busy | output | 1 | A sweep or its write-back is in progress |
| overflow | output | 1 | One-cycle pulse: a sample was dropped |
| cf_we | input | 1 | Weight write strobe |
| cf_bin | input | BIN_W | Global bin index for the weight |
| cf_re | input | DATA_W | Weight real part, signed |
| cf_im | input | DATA_W | Weight imaginary part, signed |
| rd_bin | input | BIN_W | Global bin index to read |
| rd_re | output | ACC_W | Real sum of the bin read |
| rd_im | output | ACC_W | Imaginary sum of the bin read |

## Verification
The bench builds the block with two lanes of two bins each, 16-bit data and 48-bit sums. With only two bins per lane, a sample accepted on the last step of one sweep reads bin 0 on the same edge as the earlier write to bin 0. This exercises the forwarding path that longer sweeps never reach. Two lanes are enough to show the lane/slot split of the global bin number and that weights stay separate. The short sweep also lets every sum and the exact `busy` length be checked in a few cycles.

// File: rtl/binmac_pkg.sv
// Shared types for the bin accumulator.
// Assumes nothing beyond standard SystemVerilog.
package binmac_pkg;
    // Operation the sequencer is currently issuing.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_MAC   = 2'd1,
        OP_CLEAR = 2'd2
    } binmac_op_t;
endpackage

// File: rtl/binmac_seq.sv
// Sweep sequencer shared by all lanes.
// Accepts a sample or a clear when idle or on the last bin step,
// then issues one bin address per clock together with the latched sample.
// Assumes BINS >= 1 and LW wide enough to hold BINS-1.
module binmac_seq
    import binmac_pkg::*;
#(
    parameter int BINS = 50,
    parameter int DW   = 16,
    parameter int LW   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_re,
    input  logic signed [DW-1:0] smp_im,
    input  logic                 clr_req,
    output logic                 iss_valid,
    output logic                 iss_clr,
    output logic [LW-1:0]        iss_addr,
    output logic signed [DW-1:0] iss_re,
    output logic signed [DW-1:0] iss_im,
    output logic                 ovf
);
    localparam logic [LW-1:0] LAST = LW'(BINS - 1);

    binmac_op_t           op;
    logic [LW-1:0]        addr;
    logic signed [DW-1:0] lat_re;
    logic signed [DW-1:0] lat_im;
    logic                 free;

    // A new sweep may start when idle or on the final bin step.
    always_comb free = (op == OP_IDLE) || (addr == LAST);

    // Sweep state, address counter and sample latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op     <= OP_IDLE;
            addr   <= '0;
            lat_re <= '0;
            lat_im <= '0;
            ovf    <= 1'b0;
        end else begin
            ovf <= smp_valid && !free;
            if (free && clr_req) begin
                op   <= OP_CLEAR;
                addr <= '0;
            end else if (free && smp_valid) begin
                op     <= OP_MAC;
                addr   <= '0;
                lat_re <= smp_re;
                lat_im <= smp_im;
            end else if (op != OP_IDLE) begin
                if (addr == LAST) begin
                    op   <= OP_IDLE;
                    addr <= '0;
                end else begin
                    addr <= addr + 1'b1;
                end
            end
        end
    end

    // Issue bundle seen by every lane.
    always_comb begin
        iss_valid = (op != OP_IDLE);
        iss_clr   = (op == OP_CLEAR);
        iss_addr  = addr;
        iss_re    = lat_re;
        iss_im    = lat_im;
    end

    // R3: a dropped sample leaves the latched sample untouched.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !free) |=> ($stable(lat_re) && $stable(lat_im)))
        else $error("R3: sample taken mid-sweep");

    // R6: inside a sweep the address steps by one each clock.
    assert_sweep_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_IDLE && addr != LAST) |=> (op == $past(op) && addr == LW'($past(addr) + 1'b1)))
        else $error("R6: sweep step broken");

    // R10: a clear seen while free starts a clear sweep at bin 0.
    assert_clear_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (free && clr_req) |=> (op == OP_CLEAR && addr == '0))
        else $error("R10: clear not given priority");
endmodule

// File: rtl/binmac_coef_ram.sv
// Weight memory for one lane: one write port, one registered read port.
// Read-first on a same-address collision. Contents are not reset.
module binmac_coef_ram #(
    parameter int DEPTH = 50,
    parameter int W     = 32,
    parameter int AWD   = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AWD-1:0] waddr,
    input  logic [W-1:0]   wdata,
    input  logic [AWD-1:0] raddr,
    output logic [W-1:0]   rdata
);
    logic [W-1:0] mem [DEPTH];

    // Weight write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port feeding the multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end

    // R9: weight writes stay inside the lane's slots.
    assert_coef_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({1'b0, waddr} < (AWD+1)'(DEPTH)))
        else $error("R9: weight address out of range");
endmodule

// File: rtl/binmac_acc_ram.sv
// Accumulator memory for one lane. Port A is the sweep's read and write-back.
// Port B is an independent registered read for result readout.
// Both reads are read-first. Contents are not reset; a clear sweep zeroes them.
module binmac_acc_ram #(
    parameter int DEPTH = 50,
    parameter int W     = 96,
    parameter int AWD   = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AWD-1:0] waddr,
    input  logic [W-1:0]   wdata,
    input  logic [AWD-1:0] ra_addr,
    output logic [W-1:0]   ra_data,
    input  logic [AWD-1:0] rb_addr,
    output logic [W-1:0]   rb_data
);
    logic [W-1:0] mem [DEPTH];

    // Write-back from the adder stage.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Sweep read and readout read, both registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_data <= '0;
            rb_data <= '0;
        end else begin
            ra_data <= mem[ra_addr];
            rb_data <= mem[rb_addr];
        end
    end

    // R9: write-back stays inside the lane's slots.
    assert_acc_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({1'b0, waddr} < (AWD+1)'(DEPTH)))
        else $error("R9: accumulator address out of range");
endmodule

// File: rtl/binmac_cmul.sv
// Registered complex multiplier built from four real products.
// p_re = a_re*b_re - a_im*b_im, p_im = a_re*b_im + a_im*b_re.
// The output is one bit wider than a real product so it never overflows.
module binmac_cmul #(
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [DW-1:0]  a_re,
    input  logic signed [DW-1:0]  a_im,
    input  logic signed [DW-1:0]  b_re,
    input  logic signed [DW-1:0]  b_im,
    output logic signed [2*DW:0]  p_re,
    output logic signed [2*DW:0]  p_im
);
    logic signed [2*DW-1:0] m_rr, m_ii, m_ri, m_ir;

    // Four real partial products.
    always_comb begin
        m_rr = a_re * b_re;
        m_ii = a_im * b_im;
        m_ri = a_re * b_im;
        m_ir = a_im * b_re;
    end

    // Combine and register the partial products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_re <= '0;
            p_im <= '0;
        end else begin
            p_re <= $signed({m_rr[2*DW-1], m_rr}) - $signed({m_ii[2*DW-1], m_ii});
            p_im <= $signed({m_ri[2*DW-1], m_ri}) + $signed({m_ir[2*DW-1], m_ir});
        end
    end
endmodule

// File: rtl/binmac_lane.sv
// One MAC lane: weight memory, accumulator memory and complex multiplier.
// Pipeline: S0 issue/read, S1 multiply, S2 add and write-back.
// Writes still in flight are forwarded to a newer read of the same slot.
// Assumes AW > 2*DW+1.
module binmac_lane #(
    parameter int BINS = 50,
    parameter int DW   = 16,
    parameter int AW   = 48,
    parameter int LW   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic                 iss_clr,
    input  logic [LW-1:0]        iss_addr,
    input  logic signed [DW-1:0] iss_re,
    input  logic signed [DW-1:0] iss_im,
    input  logic                 cw_en,
    input  logic [LW-1:0]        cw_addr,
    input  logic signed [DW-1:0] cw_re,
    input  logic signed [DW-1:0] cw_im,
    input  logic [LW-1:0]        rd_addr,
    output logic [AW-1:0]        rd_re,
    output logic [AW-1:0]        rd_im,
    output logic                 pend
);
    localparam int PW = 2 * DW + 1;

    logic [2*DW-1:0]      coef_q;
    logic [2*AW-1:0]      acc_q;
    logic [2*AW-1:0]      acc_sel;
    logic [2*AW-1:0]      fwd_val;
    logic                 fwd_hit;
    logic                 s1_valid, s1_clr;
    logic [LW-1:0]        s1_addr;
    logic signed [DW-1:0] s1_re, s1_im;
    logic                 s2_valid, s2_clr;
    logic [LW-1:0]        s2_addr;
    logic [2*AW-1:0]      s2_acc;
    logic signed [PW-1:0] p_re, p_im;
    logic [AW-1:0]        wr_re, wr_im;

    binmac_coef_ram #(.DEPTH(BINS), .W(2*DW), .AWD(LW)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cw_en),
        .waddr (cw_addr),
        .wdata ({cw_re, cw_im}),
        .raddr (iss_addr),
        .rdata (coef_q)
    );

    binmac_acc_ram #(.DEPTH(BINS), .W(2*AW), .AWD(LW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (s2_valid),
        .waddr   (s2_addr),
        .wdata   ({wr_re, wr_im}),
        .ra_addr (iss_addr),
        .ra_data (acc_q),
        .rb_addr (rd_addr),
        .rb_data ({rd_re, rd_im})
    );

    binmac_cmul #(.DW(DW)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .a_re  (s1_re),
        .a_im  (s1_im),
        .b_re  ($signed(coef_q[2*DW-1:DW])),
        .b_im  ($signed(coef_q[DW-1:0])),
        .p_re  (p_re),
        .p_im  (p_im)
    );

    // S2 sum with sign-extended product; a clear sweep writes zero.
    always_comb begin
        if (s2_clr) begin
            wr_re = '0;
            wr_im = '0;
        end else begin
            wr_re = s2_acc[2*AW-1:AW] + {{(AW-PW){p_re[PW-1]}}, p_re};
            wr_im = s2_acc[AW-1:0]    + {{(AW-PW){p_im[PW-1]}}, p_im};
        end
    end

    // S1 operand choice: newest in-flight write first, then captured write, then memory.
    always_comb begin
        if (s2_valid && s2_addr == s1_addr) acc_sel = {wr_re, wr_im};
        else if (fwd_hit)                   acc_sel = fwd_val;
        else                                acc_sel = acc_q;
    end

    // S0 to S1 stage, catching a write that lands on the same edge as the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_clr   <= 1'b0;
            s1_addr  <= '0;
            s1_re    <= '0;
            s1_im    <= '0;
            fwd_hit  <= 1'b0;
            fwd_val  <= '0;
        end else begin
            s1_valid <= iss_valid;
            s1_clr   <= iss_clr;
            s1_addr  <= iss_addr;
            s1_re    <= iss_re;
            s1_im    <= iss_im;
            fwd_hit  <= iss_valid && s2_valid && (s2_addr == iss_addr);
            fwd_val  <= {wr_re, wr_im};
        end
    end

    // S1 to S2 stage carrying the resolved accumulator value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_clr   <= 1'b0;
            s2_addr  <= '0;
            s2_acc   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_clr   <= s1_clr;
            s2_addr  <= s1_addr;
            s2_acc   <= acc_sel;
        end
    end

    // Work still in the pipeline after the issue stage.
    always_comb pend = s1_valid || s2_valid;

    // R7: every write-back comes from an issue two cycles earlier.
    assert_pipe_flow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |-> $past(iss_valid, 2))
        else $error("R7: write-back without matching issue");
endmodule

// File: rtl/binmac_bank.sv
// Top level: one shared sequencer driving LANES identical MAC lanes.
// Global bin g lives in lane g / BINS_PER_LANE, slot g mod BINS_PER_LANE.
// Readout is registered through the lane memories' second port.
module binmac_bank #(
    parameter int LANES         = 4,
    parameter int BINS_PER_LANE = 50,
    parameter int DATA_W        = 16,
    parameter int ACC_W         = 48,
    localparam int TOTAL = LANES * BINS_PER_LANE,
    localparam int BIN_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] smp_re,
    input  logic signed [DATA_W-1:0] smp_im,
    input  logic                     clr_req,
    output logic                     busy,
    output logic                     overflow,
    input  logic                     cf_we,
    input  logic [BIN_W-1:0]         cf_bin,
    input  logic signed [DATA_W-1:0] cf_re,
    input  logic signed [DATA_W-1:0] cf_im,
    input  logic [BIN_W-1:0]         rd_bin,
    output logic [ACC_W-1:0]         rd_re,
    output logic [ACC_W-1:0]         rd_im
);
    localparam int LW = (BINS_PER_LANE > 1) ? $clog2(BINS_PER_LANE) : 1;
    localparam int BX = BIN_W + 1;

    logic                     iss_valid, iss_clr;
    logic [LW-1:0]            iss_addr;
    logic signed [DATA_W-1:0] iss_re, iss_im;
    logic [BX-1:0]            cf_lane, rd_lane, rd_lane_q;
    logic [LW-1:0]            cf_loc, rd_loc;
    logic [LANES-1:0]         pend;
    logic [ACC_W-1:0]         lane_re [LANES];
    logic [ACC_W-1:0]         lane_im [LANES];

    binmac_seq #(.BINS(BINS_PER_LANE), .DW(DATA_W), .LW(LW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_re    (smp_re),
        .smp_im    (smp_im),
        .clr_req   (clr_req),
        .iss_valid (iss_valid),
        .iss_clr   (iss_clr),
        .iss_addr  (iss_addr),
        .iss_re    (iss_re),
        .iss_im    (iss_im),
        .ovf       (overflow)
    );

    // Split global bin numbers into lane and slot.
    always_comb begin
        cf_lane = {1'b0, cf_bin} / BX'(BINS_PER_LANE);
        cf_loc  = LW'({1'b0, cf_bin} % BX'(BINS_PER_LANE));
        rd_lane = {1'b0, rd_bin} / BX'(BINS_PER_LANE);
        rd_loc  = LW'({1'b0, rd_bin} % BX'(BINS_PER_LANE));
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        binmac_lane #(.BINS(BINS_PER_LANE), .DW(DATA_W), .AW(ACC_W), .LW(LW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .iss_valid (iss_valid),
            .iss_clr   (iss_clr),
            .iss_addr  (iss_addr),
            .iss_re    (iss_re),
            .iss_im    (iss_im),
            .cw_en     (cf_we && (cf_lane == BX'(i))),
            .cw_addr   (cf_loc),
            .cw_re     (cf_re),
            .cw_im     (cf_im),
            .rd_addr   (rd_loc),
            .rd_re     (lane_re[i]),
            .rd_im     (lane_im[i]),
            .pend      (pend[i])
        );
    end

    // Lane index registered to line up with the lanes' registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_lane_q <= '0;
        else        rd_lane_q <= rd_lane;
    end

    // Readout select; an index past the last bin returns zero.
    always_comb begin
        rd_re = '0;
        rd_im = '0;
        for (int i = 0; i < LANES; i++) begin
            if (rd_lane_q == BX'(i)) begin
                rd_re = lane_re[i];
                rd_im = lane_im[i];
            end
        end
    end

    // Busy while issuing or while any write-back is outstanding.
    always_comb busy = iss_valid || (|pend);

    // R8: a read of a nonexistent bin returns zero on the next cycle.
    assert_rd_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_bin} >= BX'(TOTAL)) |=> (rd_re == '0 && rd_im == '0))
        else $error("R8: out-of-range read not zero");
endmodule

// File: tb/binmac_bank_test.sv
// Directed bench for binmac_bank: one task per scenario, each checking itself.
module binmac_bank_test;
    localparam int LN  = 2;
    localparam int BN  = 2;
    localparam int DW  = 16;
    localparam int AW  = 48;
    localparam int TOT = LN * BN;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_valid = 1'b0;
    logic signed [DW-1:0] smp_re = '0;
    logic signed [DW-1:0] smp_im = '0;
    logic                 clr_req = 1'b0;
    logic                 cf_we = 1'b0;
    logic [1:0]           cf_bin = '0;
    logic signed [DW-1:0] cf_re = '0;
    logic signed [DW-1:0] cf_im = '0;
    logic [1:0]           rd_bin = '0;
    logic                 busy, overflow;
    logic [AW-1:0]        rd_re, rd_im;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    longint        w_re [TOT];
    longint        w_im [TOT];
    logic [AW-1:0] e_re [TOT];
    logic [AW-1:0] e_im [TOT];

    binmac_bank #(.LANES(LN), .BINS_PER_LANE(BN), .DATA_W(DW), .ACC_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_re(smp_re), .smp_im(smp_im),
        .clr_req(clr_req), .busy(busy), .overflow(overflow), .cf_we(cf_we), .cf_bin(cf_bin),
        .cf_re(cf_re), .cf_im(cf_im), .rd_bin(rd_bin), .rd_re(rd_re), .rd_im(rd_im)
    );

    always #4 clk = ~clk;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model: one accepted sample added into every bin.
    task automatic model_add(longint ar, longint ai);
        for (int g = 0; g < TOT; g++) begin
            longint pr = ar * w_re[g] - ai * w_im[g];
            longint pi = ar * w_im[g] + ai * w_re[g];
            e_re[g] = e_re[g] + pr[AW-1:0];
            e_im[g] = e_im[g] + pi[AW-1:0];
        end
    endtask

    task automatic model_zero();
        for (int g = 0; g < TOT; g++) begin
            e_re[g] = '0;
            e_im[g] = '0;
        end
    endtask

    task automatic load_w(int g, int re, int im);
        @(negedge clk);
        cf_we = 1'b1; cf_bin = 2'(g); cf_re = DW'(re); cf_im = DW'(im);
        @(negedge clk);
        cf_we = 1'b0;
        w_re[g] = longint'(re);
        w_im[g] = longint'(im);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    endtask

    // Read every bin; data is expected one cycle after the index.
    task automatic read_all(string req);
        for (int g = 0; g < TOT; g++) begin
            @(negedge clk);
            rd_bin = 2'(g);
            @(negedge clk);
            check(req, $sformatf("bin%0d re", g), 64'(rd_re), 64'(e_re[g]));
            check(req, $sformatf("bin%0d im", g), 64'(rd_im), 64'(e_im[g]));
        end
    endtask

    task automatic send(int re, int im);
        @(negedge clk);
        smp_valid = 1'b1; smp_re = DW'(re); smp_im = DW'(im);
        @(negedge clk);
        smp_valid = 1'b0;
        model_add(longint'(re), longint'(im));
        wait_idle();
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        model_zero();
        wait_idle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "busy", 64'(busy), 64'd0);
        check("R1", "overflow", 64'(overflow), 64'd0);
        check("R1", "rd_re", 64'(rd_re), 64'd0);
        check("R1", "rd_im", 64'(rd_im), 64'd0);
    endtask

    task automatic t_clear();
        int cnt = 0;
        @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        check("R2", "busy during clear", 64'(busy), 64'd1);
        for (int k = 0; k < 50 && busy; k++) begin
            cnt++;
            @(negedge clk);
        end
        check("R6", "clear busy cycles", 64'(cnt), 64'(BN + 2));
        model_zero();
        read_all("R2");
    endtask

    task automatic t_single();
        load_w(0, 3, -2);
        load_w(1, -7, 5);
        load_w(2, 100, 11);
        load_w(3, -1, -1);
        send(9, -4);
        read_all("R4");
    endtask

    task automatic t_accum();
        send(-13, 21);
        read_all("R5");
        load_w(2, 6, -9);
        send(5, 8);
        read_all("R9");
    endtask

    // Sweep length with readout traffic running alongside.
    task automatic t_read_during();
        int cnt = 0;
        @(negedge clk);
        smp_valid = 1'b1; smp_re = 16'sd40; smp_im = -16'sd3;
        @(negedge clk);
        smp_valid = 1'b0;
        model_add(40, -3);
        for (int k = 0; k < 50 && busy; k++) begin
            cnt++;
            rd_bin = 2'(k);
            @(negedge clk);
        end
        check("R8", "busy cycles with reads", 64'(cnt), 64'(BN + 2));
        check("R6", "busy low after sweep", 64'(busy), 64'd0);
        read_all("R8");
    endtask

    // Sample A, dropped X, then B on the final step of A's sweep.
    task automatic t_back_to_back();
        @(negedge clk);
        smp_valid = 1'b1; smp_re = 16'sd17; smp_im = 16'sd2;
        @(negedge clk);
        smp_re = 16'sd999; smp_im = 16'sd999;
        @(negedge clk);
        check("R3", "overflow after drop", 64'(overflow), 64'd1);
        smp_re = -16'sd6; smp_im = 16'sd31;
        @(negedge clk);
        smp_valid = 1'b0;
        check("R3", "overflow single pulse", 64'(overflow), 64'd0);
        check("R7", "busy across sweeps", 64'(busy), 64'd1);
        model_add(17, 2);
        model_add(-6, 31);
        wait_idle();
        read_all("R7");
    endtask

    task automatic t_clear_rules();
        @(negedge clk);
        clr_req = 1'b1; smp_valid = 1'b1; smp_re = 16'sd5; smp_im = 16'sd5;
        @(negedge clk);
        clr_req = 1'b0; smp_valid = 1'b0;
        check("R10", "no overflow on clear+sample", 64'(overflow), 64'd0);
        model_zero();
        wait_idle();
        read_all("R10");
        @(negedge clk);
        smp_valid = 1'b1; smp_re = 16'sd12; smp_im = -16'sd8;
        @(negedge clk);
        smp_valid = 1'b0; clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        model_add(12, -8);
        wait_idle();
        read_all("R10");
    endtask

    task automatic t_extreme();
        do_clear();
        load_w(0, -32768, -32768);
        load_w(1, 32767, 32767);
        load_w(2, 32767, -32768);
        load_w(3, -32768, 32767);
        send(-32768, 32767);
        send(-32768, -32768);
        read_all("R11");
    endtask

    initial begin
        model_zero();
        for (int g = 0; g < TOT; g++) begin
            w_re[g] = 0;
            w_im[g] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clear();
        t_single();
        t_accum();
        t_read_during();
        t_back_to_back();
        t_clear_rules();
        t_extreme();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        #1200000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule